// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block receives configuration words over a three-wire serial link made of a serial clock, a serial data line and a latch-enable strobe. All three lines come from outside the system clock domain. They pass through synchronizer flops, and their edges are detected with the system clock. Each rising edge of the serial clock moves one data bit into an 18-bit shift register, most significant bit first.

A rising edge of latch enable transfers the frame to one of two parallel configuration registers. The destination is picked by the last bit shifted in. The other 17 bits become the new register contents. The meaning of the individual configuration fields is left to the blocks that use them. Each register has a one-cycle update strobe, so those blocks know when to reload.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is high, and right after it, both configuration registers read zero and both update strobes are low.
- R2: Bits are captured only on a rising edge of the serial clock. Changes of the data line while the serial clock is high, or at its falling edge, do not alter what is captured.
- R3: A frame is 18 bits sent most significant bit first. The first 17 bits shifted in become register bits 16 down to 0, with the first bit landing in bit 16. The 18th bit shifted in is the address.
- R4: Address value 0 selects the reference-divider register (`ref_cfg`). Address value 1 selects the feedback-divider register (`fb_cfg`).
- R5: When latch enable rises, the register that is not addressed keeps its previous value.
- R6: When more than 18 bits are shifted before a latch, only the most recent 18 bits form the frame.
- R7: A transfer happens only on the rising edge of latch enable. Shifting while latch enable is held high, and the falling edge of latch enable, leave both registers unchanged.
- R8: The update strobe of the addressed register is high for exactly one system clock, in the first cycle the new value is visible. The other strobe stays low.
- R9: Latch enable is sampled high at one system clock edge. The new register value and its strobe then appear after the third system clock edge, counting that sampling edge as the first, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, asynchronous to clk |
| ser_le | input | 1 | Latch enable, asynchronous to clk |
| ref_cfg | output | 17 | Reference-divider configuration register |
| fb_cfg | output | 17 | Feedback-divider configuration register |
| ref_upd | output | 1 | One-cycle strobe after ref_cfg loads |
| fb_upd | output | 1 | One-cycle strobe after fb_cfg loads |

## Verification
A walking-one sweep over all 17 data bits for each address shows whether any bit is misplaced, reversed or dropped. It also shows whether the address bit selects the wrong register. Arithmetically generated words with alternating addresses confirm that the non-addressed register holds its value. While the serial clock is high, the data line is toggled to a wrong value, so a capture on the wrong edge shows up as corrupted data. Over-length frames and frames shifted while latch enable is held high separate keeping the last 18 bits from keeping the first 18, and a true edge-triggered transfer from a level-triggered one.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;

  // Destination selected by the final bit of a frame
  typedef enum logic {
    SEL_REF = 1'b0,
    SEL_FB  = 1'b1
  } cfg_sel_e;

  localparam int NUM_DEST = 2;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_lvl,
  input  logic               sdat_lvl,
  output logic [FRAME_W-1:0] frame
);

  logic sclk_prev;
  logic sclk_rise;

  assign sclk_rise = sclk_lvl & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      frame     <= '0;
    end else begin
      sclk_prev <= sclk_lvl;
      if (sclk_rise) frame <= {frame[FRAME_W-2:0], sdat_lvl};
    end
  end

  // R2: without a serial clock rise the frame does not move
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(frame));

  // R3/R6: each rise moves the older bits up by one place
  a_r6_shift_up: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_ser_pkg::*;
#(
  parameter int FRAME_W = 18,
  localparam int DATA_W = FRAME_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               le_lvl,
  input  logic [FRAME_W-1:0] frame,
  output logic [DATA_W-1:0]  dest_q   [NUM_DEST],
  output logic [NUM_DEST-1:0] dest_upd
);

  logic     le_prev;
  logic     le_rise;
  cfg_sel_e sel;

  assign le_rise = le_lvl & ~le_prev;
  assign sel     = cfg_sel_e'(frame[0]);

  always_ff @(posedge clk) begin
    if (rst) le_prev <= 1'b0;
    else     le_prev <= le_lvl;
  end

  generate
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
      always_ff @(posedge clk) begin
        if (rst) begin
          dest_q[d]   <= '0;
          dest_upd[d] <= 1'b0;
        end else begin
          dest_upd[d] <= 1'b0;
          if (le_rise && (int'(sel) == d)) begin
            dest_q[d]   <= frame[FRAME_W-1:1];
            dest_upd[d] <= 1'b1;
          end
        end
      end

      // R8: strobe never lasts two cycles
      a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dest_upd[d] |=> !dest_upd[d]);

      // R5/R7: value changes only in a strobe cycle
      a_r5_hold_unless_loaded: assert property (@(posedge clk) disable iff (rst)
        !dest_upd[d] |-> $stable(dest_q[d]));
    end
  endgenerate

  // R8: at most one destination updates at a time
  a_r8_one_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dest_upd));

  // R4: the ref strobe follows a latch addressed to ref
  a_r4_ref_addressed: assert property (@(posedge clk) disable iff (rst)
    (le_rise && sel == SEL_REF) |=> dest_upd[0] && !dest_upd[1]);

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_ser_pkg::*;
#(
  parameter int FRAME_W     = 18,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = FRAME_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [DATA_W-1:0] ref_cfg,
  output logic [DATA_W-1:0] fb_cfg,
  output logic              ref_upd,
  output logic              fb_upd
);

  logic [2:0]          pins_sync;
  logic [FRAME_W-1:0]  frame;
  logic [DATA_W-1:0]   dest_q [NUM_DEST];
  logic [NUM_DEST-1:0] dest_upd;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({ser_le, ser_dat, ser_clk}),
    .d_out (pins_sync)
  );

  cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_lvl (pins_sync[0]),
    .sdat_lvl (pins_sync[1]),
    .frame    (frame)
  );

  cfg_latch #(.FRAME_W(FRAME_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .le_lvl   (pins_sync[2]),
    .frame    (frame),
    .dest_q   (dest_q),
    .dest_upd (dest_upd)
  );

  assign ref_cfg = dest_q[SEL_REF];
  assign fb_cfg  = dest_q[SEL_FB];
  assign ref_upd = dest_upd[SEL_REF];
  assign fb_upd  = dest_upd[SEL_FB];

  // R1: the cycle after reset shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (ref_cfg == '0 && fb_cfg == '0 && !ref_upd && !fb_upd));

endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [DW-1:0] ref_cfg, fb_cfg;
  logic ref_upd, fb_upd;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] exp_ref = '0, exp_fb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_cfg(ref_cfg), .fb_cfg(fb_cfg), .ref_upd(ref_upd), .fb_upd(fb_upd)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One serial bit; data is corrupted while the serial clock is high (R2)
  task automatic send_bit(logic b);
    @(negedge clk); ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    ser_dat = ~b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    ser_dat = ~b;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
  endtask

  // Latch with latency check (R9), strobe check (R8)
  task automatic strobe_le(logic sel, string tag);
    logic [DW-1:0] old_ref = ref_cfg, old_fb = fb_cfg;
    @(negedge clk); ser_le = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({"R9 early ref ", tag}, ref_cfg, old_ref);
    check({"R9 early fb ", tag}, fb_cfg, old_fb);
    check({"R9 early strobes ", tag}, {ref_upd, fb_upd}, 2'b00);
    @(posedge clk); @(negedge clk);
    check({"R3 R4 ref ", tag}, ref_cfg, exp_ref);
    check({"R3 R4 fb ", tag}, fb_cfg, exp_fb);
    check({"R8 strobe on ", tag}, {ref_upd, fb_upd}, sel ? 2'b01 : 2'b10);
    @(posedge clk); @(negedge clk);
    check({"R8 strobe off ", tag}, {ref_upd, fb_upd}, 2'b00);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(logic sel, logic [DW-1:0] val, string tag);
    send_bits({46'd0, val, sel}, 18);
    if (sel) exp_fb = val; else exp_ref = val;
    strobe_le(sel, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ref reset", ref_cfg, 0);
    check("R1 fb reset", fb_cfg, 0);
    check("R1 strobes reset", {ref_upd, fb_upd}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {ref_cfg, fb_cfg, ref_upd, fb_upd}, 0);

    // R3 R4 R5: walking one per address
    for (int b = 0; b < DW; b++) begin
      write_word(1'b0, DW'(1) << b, "walk ref");
      write_word(1'b1, DW'(1) << b, "walk fb");
    end

    // R5: arithmetic words, alternating destination
    for (int k = 0; k < 12; k++) begin
      logic [DW-1:0] v = DW'((k * 12345 + 777) % (1 << DW));
      write_word(k[0], v, "arith R5");
    end
    write_word(1'b0, '1, "ones");
    write_word(1'b1, '0, "zeros");

    // R6: 7 extra leading bits, only last 18 count
    send_bits({39'd0, 7'b1011011, 17'h15A5C, 1'b1}, 25);
    exp_fb = 17'h15A5C;
    strobe_le(1'b1, "R6 overlength");
    send_bits({33'd0, 13'h1FFF, 17'h0F0F1, 1'b0}, 31);
    exp_ref = 17'h0F0F1;
    strobe_le(1'b0, "R6 overlength ref");

    // R7: shifting with latch held high, then falling edge, no load
    @(negedge clk); ser_le = 1'b1;
    repeat (6) @(negedge clk);
    send_bits({46'd0, 17'h1234B, 1'b0}, 18);
    repeat (6) @(negedge clk);
    check("R7 no load while high ref", ref_cfg, exp_ref);
    check("R7 no strobe while high", {ref_upd, fb_upd}, 0);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 no load on fall ref", ref_cfg, exp_ref);
    check("R7 no load on fall fb", fb_cfg, exp_fb);
    exp_ref = 17'h1234B;
    strobe_le(1'b0, "R7 next rise");

    finish_run();
  end

endmodule